// File: doc/BRIEF.md
# DMA Channel Block Sequencer

This block is the control engine of one DMA channel. Software programs the start addresses of both sides, a block length counted in source items, a width code and a burst code for each side, per-side increment enables, and per-side auto-reload enables. A start pulse launches the channel. It then alternates between read and write transaction requests on two simple request/acknowledge ports until the whole block has moved. Each request carries an address, a beat count and a beat size. The data path, bus master, peripheral handshakes and descriptor fetch all live outside the block.

The channel moves data in chunks. One read burst of up to the source burst size fetches a chunk. That chunk is then written out in destination-width beats, each write burst no longer than the destination burst size. When a block ends with a reload enable set, the channel starts another block. A side with reload set returns to its start address; the other side carries on from where it stopped. Software clears the reload enables during a block to make that block the last one. A suspend input holds back new requests, and an inactive output shows when nothing is outstanding.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset there are no requests and no interrupts, `busy` is 0 and `inactive` is 1.
- R2: Width code 0, 1 or 2 selects 1, 2 or 4 bytes per item, and this code appears unchanged on `rd_size`/`wr_size`. Burst code 0, 1, 2 or 3 selects 1, 4, 8 or 16 items per transaction.
- R3: Each read asks for min(source burst items, items left in block). The final read of a block is therefore shortened, and every block reads exactly the programmed length.
- R4: With its increment enable set, a side's address advances by beats × width bytes after each acknowledged transaction. With it clear, the address stays fixed.
- R5: Each read chunk of N items is followed by writes that total N × source width bytes. Each write asks for min(destination burst items, remaining chunk bytes / destination width) beats. A read and a write are never requested at the same time.
- R6: `irq_block` pulses for one cycle after the last write of each block. `irq_done` pulses together with it on the final block, and `busy` then falls.
- R7: At a block end with reload enabled, the source address returns to its start when `reload_src` is 1, and the destination address returns to its start when `reload_dst` is 1. A side without reload continues contiguously.
- R8: `reload_src` and `reload_dst` are sampled at each block end. Clearing both during a block makes it the final block.
- R9: While `suspend` is 1, no new request is issued, but an outstanding request still completes. `inactive` is 1 only when no request is outstanding. Clearing `suspend` resumes with the saved addresses and count.
- R10: A start with a width code above 2, a burst code above 3, a zero length, or a total or burst byte count that is not a multiple of the destination width raises `irq_error` for one cycle. The channel does not start.
- R11: An acknowledge that arrives with its error input high raises `irq_error`, stops the channel, and produces no `irq_done`.
- R12: `stat_src_addr`, `stat_dst_addr` and `stat_count` (source items read in the current block) show live channel state at all times.
- R13: A start pulse while the channel is busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch pulse, used only when idle |
| suspend | input | 1 | Hold off new requests |
| reload_src | input | 1 | Source auto-reload enable (live) |
| reload_dst | input | 1 | Destination auto-reload enable (live) |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_dst_addr | input | ADDR_W | Destination start address |
| cfg_len | input | LEN_W | Block length in source items |
| cfg_src_width | input | 3 | Source width code |
| cfg_dst_width | input | 3 | Destination width code |
| cfg_src_burst | input | 3 | Source burst code |
| cfg_dst_burst | input | 3 | Destination burst code |
| cfg_src_inc | input | 1 | Source address increment enable |
| cfg_dst_inc | input | 1 | Destination address increment enable |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Read address |
| rd_beats | output | 5 | Read beat count (1..16) |
| rd_size | output | 2 | Read beat size code |
| rd_ack | input | 1 | Read acknowledge |
| rd_err | input | 1 | Read error, valid with acknowledge |
| wr_req | output | 1 | Write request, held until acknowledged |
| wr_addr | output | ADDR_W | Write address |
| wr_beats | output | 5 | Write beat count (1..16) |
| wr_size | output | 2 | Write beat size code |
| wr_ack | input | 1 | Write acknowledge |
| wr_err | input | 1 | Write error, valid with acknowledge |
| busy | output | 1 | Channel running |
| inactive | output | 1 | Nothing outstanding, safe to stop |
| irq_block | output | 1 | Block complete pulse |
| irq_done | output | 1 | Transfer complete pulse |
| irq_error | output | 1 | Error pulse |
| stat_src_addr | output | ADDR_W | Current source address |
| stat_dst_addr | output | ADDR_W | Current destination address |
| stat_count | output | LEN_W | Items read in current block |

## Verification
The bench sweeps every width and burst code pair and predicts each request's address, beat count and size by arithmetic. This exposes a sequencer that overruns the block on the last burst, or that writes more or fewer bytes than it read when widths differ. It runs all four reload combinations over three blocks and checks the final addresses in closed form. A sequencer that reloads the wrong side, or that reloads on the final block, ends at a different address. The bench suspends with a slow acknowledge outstanding, so a design that drops the request in flight, or that keeps issuing requests while suspended, is caught. It also sends invalid codes, misaligned lengths, bus errors, and a start pulse mid-transfer, each of which would otherwise start, finish or corrupt a transfer.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_RD_ARM = 3'd1,
        SQ_RD_REQ = 3'd2,
        SQ_WR_ARM = 3'd3,
        SQ_WR_REQ = 3'd4
    } seq_state_e;

    // burst code to item count; only codes 0..3 are legal
    function automatic logic [4:0] burst_items(input logic [1:0] code);
        case (code)
            2'd0:    return 5'd1;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/dma_code_check.sv
module dma_code_check
    import dma_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [2:0]       src_wc,
    input  logic [2:0]       dst_wc,
    input  logic [2:0]       src_bc,
    input  logic [2:0]       dst_bc,
    input  logic [LEN_W-1:0] len,
    output logic             ok,
    output logic [4:0]       src_items,
    output logic [4:0]       dst_items
);

    logic [LEN_W+1:0] len_bytes;
    logic [6:0]       burst_bytes;
    logic [1:0]       dmask;
    logic             codes_ok;

    always_comb begin
        src_items   = burst_items(src_bc[1:0]);
        dst_items   = burst_items(dst_bc[1:0]);
        len_bytes   = {2'b00, len} << src_wc[1:0];
        burst_bytes = {2'b00, src_items} << src_wc[1:0];
        case (dst_wc[1:0])
            2'd2:    dmask = 2'b11;
            2'd1:    dmask = 2'b01;
            default: dmask = 2'b00;
        endcase
        codes_ok = (src_wc <= 3'd2) && (dst_wc <= 3'd2) &&
                   (src_bc <= 3'd3) && (dst_bc <= 3'd3);
        ok = codes_ok && (len != '0) &&
             ((len_bytes[1:0] & dmask) == 2'b00) &&
             ((burst_bytes[1:0] & dmask) == 2'b00);
    end

endmodule

// File: rtl/dma_addr_track.sv
module dma_addr_track #(
    parameter int ADDR_W = 32,
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_en,
    input  logic [STEP_W-1:0] step,
    input  logic              reload,
    output logic [ADDR_W-1:0] cur
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] cur;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (load) begin
            trk_d.base = load_val;
            trk_d.cur  = load_val;
        end else if (reload) begin
            trk_d.cur = trk_q.base;
        end else if (step_en) begin
            trk_d.cur = trk_q.cur + ADDR_W'(step);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign cur = trk_q.cur;

    // R7: a reload puts the pointer back on the latched base
    a_r7_reload_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !load) |=> (cur == $past(trk_q.base)));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              suspend,
    input  logic              reload_src,
    input  logic              reload_dst,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [2:0]        cfg_src_width,
    input  logic [2:0]        cfg_dst_width,
    input  logic [2:0]        cfg_src_burst,
    input  logic [2:0]        cfg_dst_burst,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [4:0]        rd_beats,
    output logic [1:0]        rd_size,
    input  logic              rd_ack,
    input  logic              rd_err,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [4:0]        wr_beats,
    output logic [1:0]        wr_size,
    input  logic              wr_ack,
    input  logic              wr_err,
    output logic              busy,
    output logic              inactive,
    output logic              irq_block,
    output logic              irq_done,
    output logic              irq_error,
    output logic [ADDR_W-1:0] stat_src_addr,
    output logic [ADDR_W-1:0] stat_dst_addr,
    output logic [LEN_W-1:0]  stat_count
);

    localparam int BEAT_W  = 5;
    localparam int BYTE_W  = BEAT_W + 2;
    localparam int N_SIDES = 2;

    typedef struct packed {
        seq_state_e        st;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  rem;
        logic [LEN_W-1:0]  cnt;
        logic [1:0]        sw;
        logic [1:0]        dw;
        logic [BEAT_W-1:0] sbi;
        logic [BEAT_W-1:0] dbi;
        logic              sinc;
        logic              dinc;
        logic [BEAT_W-1:0] nbeat;
        logic [BYTE_W-1:0] wbytes;
        logic              irq_b;
        logic              irq_d;
        logic              irq_e;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              cfg_ok;
    logic [BEAT_W-1:0] cfg_sbi, cfg_dbi;
    logic [BEAT_W-1:0] rd_min, wr_min;
    logic [BYTE_W-1:0] wr_avail, wb_left;
    logic              trk_load;
    logic [N_SIDES-1:0] trk_step_en, trk_reload;
    logic [BYTE_W-1:0] trk_step [N_SIDES];
    logic [ADDR_W-1:0] trk_base [N_SIDES];
    logic [ADDR_W-1:0] trk_cur  [N_SIDES];

    dma_code_check #(.LEN_W(LEN_W)) u_chk (
        .src_wc    (cfg_src_width),
        .dst_wc    (cfg_dst_width),
        .src_bc    (cfg_src_burst),
        .dst_bc    (cfg_dst_burst),
        .len       (cfg_len),
        .ok        (cfg_ok),
        .src_items (cfg_sbi),
        .dst_items (cfg_dst_items_unused_guard)
    );

    logic [BEAT_W-1:0] cfg_dst_items_unused_guard;
    assign cfg_dbi = cfg_dst_items_unused_guard;

    assign trk_base[0] = cfg_src_addr;
    assign trk_base[1] = cfg_dst_addr;
    assign trk_step[0] = {2'b00, seq_q.nbeat} << seq_q.sw;
    assign trk_step[1] = {2'b00, seq_q.nbeat} << seq_q.dw;

    for (genvar g = 0; g < N_SIDES; g++) begin : g_side
        dma_addr_track #(.ADDR_W(ADDR_W), .STEP_W(BYTE_W)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (trk_load),
            .load_val (trk_base[g]),
            .step_en  (trk_step_en[g]),
            .step     (trk_step[g]),
            .reload   (trk_reload[g]),
            .cur      (trk_cur[g])
        );
    end

    always_comb begin
        if (seq_q.rem < LEN_W'(seq_q.sbi)) rd_min = seq_q.rem[BEAT_W-1:0];
        else                               rd_min = seq_q.sbi;
        wr_avail = seq_q.wbytes >> seq_q.dw;
        if (wr_avail < {2'b00, seq_q.dbi}) wr_min = wr_avail[BEAT_W-1:0];
        else                               wr_min = seq_q.dbi;
        wb_left = seq_q.wbytes - ({2'b00, seq_q.nbeat} << seq_q.dw);
    end

    always_comb begin
        seq_d       = seq_q;
        seq_d.irq_b = 1'b0;
        seq_d.irq_d = 1'b0;
        seq_d.irq_e = 1'b0;
        trk_load    = 1'b0;
        trk_step_en = '0;
        trk_reload  = '0;
        case (seq_q.st)
            SQ_IDLE: begin
                if (start) begin
                    if (cfg_ok) begin
                        seq_d.st   = SQ_RD_ARM;
                        seq_d.len  = cfg_len;
                        seq_d.rem  = cfg_len;
                        seq_d.cnt  = '0;
                        seq_d.sw   = cfg_src_width[1:0];
                        seq_d.dw   = cfg_dst_width[1:0];
                        seq_d.sbi  = cfg_sbi;
                        seq_d.dbi  = cfg_dbi;
                        seq_d.sinc = cfg_src_inc;
                        seq_d.dinc = cfg_dst_inc;
                        trk_load   = 1'b1;
                    end else begin
                        seq_d.irq_e = 1'b1;
                    end
                end
            end
            SQ_RD_ARM: begin
                if (!suspend) begin
                    seq_d.nbeat = rd_min;
                    seq_d.st    = SQ_RD_REQ;
                end
            end
            SQ_RD_REQ: begin
                if (rd_ack) begin
                    if (rd_err) begin
                        seq_d.irq_e = 1'b1;
                        seq_d.st    = SQ_IDLE;
                    end else begin
                        seq_d.rem      = seq_q.rem - LEN_W'(seq_q.nbeat);
                        seq_d.cnt      = seq_q.cnt + LEN_W'(seq_q.nbeat);
                        seq_d.wbytes   = {2'b00, seq_q.nbeat} << seq_q.sw;
                        trk_step_en[0] = seq_q.sinc;
                        seq_d.st       = SQ_WR_ARM;
                    end
                end
            end
            SQ_WR_ARM: begin
                if (!suspend) begin
                    seq_d.nbeat = wr_min;
                    seq_d.st    = SQ_WR_REQ;
                end
            end
            SQ_WR_REQ: begin
                if (wr_ack) begin
                    if (wr_err) begin
                        seq_d.irq_e = 1'b1;
                        seq_d.st    = SQ_IDLE;
                    end else begin
                        seq_d.wbytes   = wb_left;
                        trk_step_en[1] = seq_q.dinc;
                        if (wb_left != '0) begin
                            seq_d.st = SQ_WR_ARM;
                        end else if (seq_q.rem != '0) begin
                            seq_d.st = SQ_RD_ARM;
                        end else begin
                            seq_d.irq_b = 1'b1;
                            if (reload_src || reload_dst) begin
                                seq_d.rem     = seq_q.len;
                                seq_d.cnt     = '0;
                                trk_reload[0] = reload_src;
                                trk_reload[1] = reload_dst;
                                seq_d.st      = SQ_RD_ARM;
                            end else begin
                                seq_d.irq_d = 1'b1;
                                seq_d.st    = SQ_IDLE;
                            end
                        end
                    end
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign rd_req        = (seq_q.st == SQ_RD_REQ);
    assign wr_req        = (seq_q.st == SQ_WR_REQ);
    assign rd_addr       = trk_cur[0];
    assign wr_addr       = trk_cur[1];
    assign rd_beats      = seq_q.nbeat;
    assign wr_beats      = seq_q.nbeat;
    assign rd_size       = seq_q.sw;
    assign wr_size       = seq_q.dw;
    assign busy          = (seq_q.st != SQ_IDLE);
    assign inactive      = (seq_q.st == SQ_IDLE) ||
                           (suspend && ((seq_q.st == SQ_RD_ARM) || (seq_q.st == SQ_WR_ARM)));
    assign irq_block     = seq_q.irq_b;
    assign irq_done      = seq_q.irq_d;
    assign irq_error     = seq_q.irq_e;
    assign stat_src_addr = trk_cur[0];
    assign stat_dst_addr = trk_cur[1];
    assign stat_count    = seq_q.cnt;

    // R9: a pending request and its fields hold until acknowledged
    a_r9_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && $stable(rd_beats)));
    a_r9_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_beats)));
    // R9: suspend blocks any new request
    a_r9_no_new_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !rd_req) |=> !rd_req);
    a_r9_no_new_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && !wr_req) |=> !wr_req);
    // R3: a read never asks past the block end
    a_r3_rd_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_beats != '0 && LEN_W'(rd_beats) <= seq_q.rem));
    // R5: a write never asks for more bytes than the chunk holds
    a_r5_wr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_beats != '0 && (({2'b00, wr_beats} << wr_size) <= seq_q.wbytes)));
    // R6: completion always coincides with a block end
    a_r6_done_at_block: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (irq_block && !busy));
    // R10: an error leaves the channel stopped
    a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_error |-> !busy);
    // R12: progress count never exceeds the block length
    a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stat_count <= seq_q.len);

endmodule

// File: tb/sim_dma_chan_seq.sv
module sim_dma_chan_seq;

    localparam logic [31:0] SA = 32'h1000_0000;
    localparam logic [31:0] DA = 32'h2000_0800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, suspend = 1'b0, reload_src = 1'b0, reload_dst = 1'b0;
    logic [31:0] cfg_src_addr = SA, cfg_dst_addr = DA;
    logic [15:0] cfg_len = 16'd0;
    logic [2:0] cfg_src_width = 3'd0, cfg_dst_width = 3'd0;
    logic [2:0] cfg_src_burst = 3'd0, cfg_dst_burst = 3'd0;
    logic cfg_src_inc = 1'b1, cfg_dst_inc = 1'b1;
    logic rd_req, wr_req, rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_addr, wr_addr, stat_src_addr, stat_dst_addr;
    logic [4:0] rd_beats, wr_beats;
    logic [1:0] rd_size, wr_size;
    logic busy, inactive, irq_block, irq_done, irq_error;
    logic [15:0] stat_count;

    always #5 clk = ~clk;

    dma_chan_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .suspend(suspend),
        .reload_src(reload_src), .reload_dst(reload_dst),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_len(cfg_len),
        .cfg_src_width(cfg_src_width), .cfg_dst_width(cfg_dst_width),
        .cfg_src_burst(cfg_src_burst), .cfg_dst_burst(cfg_dst_burst),
        .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_beats(rd_beats), .rd_size(rd_size),
        .rd_ack(rd_ack), .rd_err(rd_err),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_beats(wr_beats), .wr_size(wr_size),
        .wr_ack(wr_ack), .wr_err(wr_err),
        .busy(busy), .inactive(inactive), .irq_block(irq_block), .irq_done(irq_done),
        .irq_error(irq_error), .stat_src_addr(stat_src_addr), .stat_dst_addr(stat_dst_addr),
        .stat_count(stat_count)
    );

    // model state, written by the setup task before start and by the responder after
    int m_sw, m_dw, m_sbi, m_dbi, m_len, m_rem, m_wb, m_blocks, m_nblk, m_items;
    int m_rd_n, m_wr_n, m_err_at, m_werr_at, ack_dly;
    bit m_sinc, m_dinc, m_done, m_err_seen;
    logic [31:0] m_src, m_dst;

    int checks = 0, errs = 0, r_checks = 0, r_errs = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic rchk(input bit ok, input string tag, input longint act, input longint exp);
        r_checks++;
        if (!ok) begin
            r_errs++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // responder: acknowledges requests and predicts each one
    initial begin
        bit rd_seen = 0, wr_seen = 0;
        int rcnt = 0, wcnt = 0;
        forever begin
            @(negedge clk);
            rd_ack = 1'b0; rd_err = 1'b0; wr_ack = 1'b0; wr_err = 1'b0;
            if (rst_n) begin
                if (rd_req && wr_req) rchk(0, "R5 read and write together", 1, 0);
                if (irq_error) m_err_seen = 1;
                if (irq_block) begin
                    rchk(m_rem == 0 && m_wb == 0, "R6 block end early", m_rem, 0);
                    m_blocks++;
                    if (reload_src || reload_dst) begin
                        rchk(!irq_done, "R8 done while reloading", irq_done, 0);
                        if (reload_src) m_src = SA;
                        if (reload_dst) m_dst = DA;
                        m_rem = m_len;
                    end else begin
                        rchk(irq_done, "R8 final block without done", irq_done, 1);
                        m_done = 1;
                    end
                end
                if (rd_req) begin
                    if (!rd_seen) begin
                        rchk(rd_addr == m_src, "R4 read address", rd_addr, m_src);
                        rchk(int'(rd_beats) == imin(m_sbi, m_rem), "R3 read beats", rd_beats, imin(m_sbi, m_rem));
                        rchk(int'(rd_size) == m_sw, "R2 read size", rd_size, m_sw);
                        rchk(int'(stat_count) == m_len - m_rem, "R12 live count", stat_count, m_len - m_rem);
                        rchk(stat_src_addr == m_src, "R12 live source", stat_src_addr, m_src);
                        rd_seen = 1; rcnt = ack_dly;
                    end
                    if (rcnt == 0) begin
                        rd_ack = 1'b1; rd_seen = 0; m_rd_n++;
                        if (m_rd_n == m_err_at) rd_err = 1'b1;
                        else begin
                            if (m_sinc) m_src = m_src + 32'(int'(rd_beats) << m_sw);
                            m_rem -= int'(rd_beats);
                            m_items += int'(rd_beats);
                            m_wb = int'(rd_beats) << m_sw;
                        end
                    end else rcnt--;
                end
                if (wr_req) begin
                    if (!wr_seen) begin
                        rchk(wr_addr == m_dst, "R4 write address", wr_addr, m_dst);
                        rchk(int'(wr_beats) == imin(m_dbi, m_wb >> m_dw), "R5 write beats", wr_beats, imin(m_dbi, m_wb >> m_dw));
                        rchk(int'(wr_size) == m_dw, "R2 write size", wr_size, m_dw);
                        wr_seen = 1; wcnt = ack_dly;
                    end
                    if (wcnt == 0) begin
                        wr_ack = 1'b1; wr_seen = 0; m_wr_n++;
                        if (m_wr_n == m_werr_at) wr_err = 1'b1;
                        else begin
                            if (m_dinc) m_dst = m_dst + 32'(int'(wr_beats) << m_dw);
                            m_wb -= int'(wr_beats) << m_dw;
                        end
                    end else wcnt--;
                end
            end
        end
    end

    task automatic setup(input int sw, dw, sb, db, input bit si, di, input int len,
                         input bit rs, rdl, input int nblk, dly, rerr, werr);
        m_sw = sw; m_dw = dw; m_sbi = (sb == 0) ? 1 : (4 << (sb - 1)); m_dbi = (db == 0) ? 1 : (4 << (db - 1));
        m_sinc = si; m_dinc = di; m_len = len; m_rem = len; m_wb = 0;
        m_src = SA; m_dst = DA; m_blocks = 0; m_nblk = nblk; m_items = 0;
        m_rd_n = 0; m_wr_n = 0; m_err_at = rerr; m_werr_at = werr; ack_dly = dly;
        m_done = 0; m_err_seen = 0;
        cfg_src_width = 3'(sw); cfg_dst_width = 3'(dw);
        cfg_src_burst = 3'(sb); cfg_dst_burst = 3'(db);
        cfg_src_inc = si; cfg_dst_inc = di; cfg_len = 16'(len);
        reload_src = rs && (nblk > 1); reload_dst = rdl && (nblk > 1);
    endtask

    task automatic final_check(input int sw, input bit si, di, input int len, input bit rs, rdl, input int nblk);
        int swb;
        logic [31:0] es, ed;
        swb = 1 << sw;
        es = SA + (si ? 32'((rs ? len : len * nblk) * swb) : 32'd0);
        ed = DA + (di ? 32'((rdl ? 1 : nblk) * len * swb) : 32'd0);
        chk(m_done, "R6 transfer complete seen", m_done, 1);
        chk(m_blocks == nblk, "R8 block count", m_blocks, nblk);
        chk(m_items == len * nblk, "R3 items read", m_items, len * nblk);
        chk(stat_src_addr == es, "R7 final source", stat_src_addr, es);
        chk(stat_dst_addr == ed, "R7 final destination", stat_dst_addr, ed);
        chk(int'(stat_count) == len, "R12 final count", stat_count, len);
        chk(!busy && inactive, "R6 idle after done", busy, 0);
    endtask

    task automatic run(input int sw, dw, sb, db, input bit si, di, input int len,
                       input bit rs, rdl, input int nblk, dly, rerr, werr, input bit poke);
        bit valid;
        int swb, dwb, sbi;
        setup(sw, dw, sb, db, si, di, len, rs, rdl, nblk, dly, rerr, werr);
        valid = (sw < 3) && (dw < 3) && (sb < 4) && (db < 4) && (len > 0);
        if (valid) begin
            swb = 1 << sw; dwb = 1 << dw; sbi = m_sbi;
            valid = ((len * swb) % dwb == 0) && ((sbi * swb) % dwb == 0);
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (!valid) begin
            chk(irq_error && !busy, "R10 rejected start", {irq_error, busy}, 2'b10);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(!rd_req && !wr_req && !busy, "R10 no activity after reject", {rd_req, wr_req, busy}, 0);
            end
            return;
        end
        chk(!irq_error, "R10 valid start accepted", irq_error, 0);
        for (int i = 0; i < 20000 && !m_done && !m_err_seen; i++) begin
            @(negedge clk);
            if (poke && i == 5) begin start = 1'b1; cfg_len = 16'd0; cfg_src_width = 3'd3; end
            if (poke && i == 6) start = 1'b0;
            if (m_blocks >= nblk - 1) begin reload_src = 1'b0; reload_dst = 1'b0; end
        end
        if (rerr != 0 || werr != 0) begin
            @(negedge clk);
            chk(m_err_seen && !m_done && !busy, "R11 bus error stops channel", {m_err_seen, m_done, busy}, 3'b100);
            return;
        end
        chk(!m_err_seen, "R13 no error from stray start", m_err_seen, 0);
        final_check(sw, si, di, len, rs, rdl, nblk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!rd_req && !wr_req && !busy && inactive, "R1 reset outputs", {rd_req, wr_req, busy, inactive}, 1);
        chk(!irq_block && !irq_done && !irq_error, "R1 reset interrupts", {irq_block, irq_done, irq_error}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R10: sweep of all width and burst code pairs
        for (int sw = 0; sw < 3; sw++)
            for (int dw = 0; dw < 3; dw++)
                for (int sb = 0; sb < 4; sb++)
                    for (int db = 0; db < 4; db++)
                        run(sw, dw, sb, db, sb != 1, db != 2, 12, 0, 0, 1, 0, 0, 0, 0);

        // R3 shortened final burst
        run(0, 0, 3, 2, 1, 1, 13, 0, 0, 1, 0, 0, 0, 0);
        run(1, 1, 2, 1, 1, 1, 37, 0, 0, 1, 1, 0, 0, 0);
        // R4 fixed addresses on both sides
        run(2, 2, 1, 1, 0, 0, 9, 0, 0, 1, 0, 0, 0, 0);

        // R7 R8 reload combinations over three blocks
        for (int c = 0; c < 4; c++)
            run(2, 1, 1, 2, 1, 1, 10, c[0], c[1], (c == 0) ? 1 : 3, 0, 0, 0, 0);
        // R8 reload cleared before the first block ends: single block
        run(0, 0, 1, 1, 1, 1, 8, 1, 1, 1, 0, 0, 0, 0);

        // R10 bad codes, zero length, misaligned total
        run(3, 0, 0, 0, 1, 1, 8, 0, 0, 1, 0, 0, 0, 0);
        run(0, 4, 0, 0, 1, 1, 8, 0, 0, 1, 0, 0, 0, 0);
        run(0, 0, 5, 0, 1, 1, 8, 0, 0, 1, 0, 0, 0, 0);
        run(0, 0, 0, 4, 1, 1, 8, 0, 0, 1, 0, 0, 0, 0);
        run(1, 1, 1, 1, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        run(0, 2, 2, 0, 1, 1, 10, 0, 0, 1, 0, 0, 0, 0);

        // R11 bus errors on read and on write
        run(1, 1, 1, 1, 1, 1, 16, 0, 0, 1, 0, 2, 0, 0);
        run(1, 1, 1, 1, 1, 1, 16, 0, 0, 1, 0, 0, 3, 0);

        // R13 start pulse while busy is ignored
        run(0, 0, 0, 0, 1, 1, 20, 0, 0, 1, 0, 0, 0, 1);

        // R9 suspend with a slow acknowledge outstanding
        setup(2, 2, 1, 1, 1, 1, 16, 0, 0, 1, 3, 0, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20 && !rd_req; i++) @(negedge clk);
        suspend = 1'b1;
        chk(rd_req && !inactive, "R9 inactive low while request pending", inactive, 0);
        repeat (8) @(negedge clk);
        chk(m_rd_n == 1, "R9 pending read completed", m_rd_n, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!rd_req && !wr_req && inactive, "R9 quiet while suspended", {rd_req, wr_req, inactive}, 1);
        end
        chk(int'(stat_count) == 4, "R9 count held during suspend", stat_count, 4);
        suspend = 1'b0;
        for (int i = 0; i < 2000 && !m_done; i++) @(negedge clk);
        final_check(2, 1, 1, 16, 0, 0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks + r_checks, errs + r_errs);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks + r_checks + 1, errs + r_errs + 1);
        $finish;
    end

endmodule